// File: doc/BRIEF.md
# Command Stream Parser

The parser sits in a channel's command path. It takes 32-bit words on a valid/ready input and tells apart the command words from the data words that trail them. For each accepted word it presents one decoded record on its output. The record holds the opcode, the fields pulled from a command word, a flag that marks trailing words, a flag that marks gather address words, and the register offset that a trailing data word is aimed at. Fetching gathered memory, taking locks and carrying out register writes are left to later stages.

How many words trail a command depends on the opcode. It can be the number of set bits in a mask, an explicit 16-bit count, a fixed one or two address words, or a length that an earlier payload-setting command left in a small register. The record is formed combinationally from the input word and the parser's state. The handshake passes straight through, so a stalled consumer stalls the producer and the state waits in place.

Top module: `cmd_stream_parser`

## Requirements
- R1: The opcode is taken from in_word[31:28] and shown on out_opcode for a command word. Opcodes 0x0 to 0xE are defined in the order setclass, incr, nonincr, mask, imm, restart, gather, setstrmid, setappid, setpyld, incr_w, nonincr_w, gather_w, restart_w and extend. Opcode 0xF sets out_unknown, and no words trail it.
- R2: Setclass (0x0) gives out_class = bits 15:6, out_offset = bits 27:16 and out_mask = bits 5:0. The number of trailing words equals the set-bit count of that 6-bit mask. The trailing data words target base + b for each set bit b, taken in ascending order.
- R3: Incr (0x1) and nonincr (0x2) give out_offset = bits 27:16 and out_count = bits 15:0, and exactly that many data words trail them. Incr targets base, base+1, and so on. Nonincr targets base for every word. A count of zero makes the next word a command.
- R4: Mask (0x3) gives out_offset = bits 27:16 and out_mask = bits 15:0. The number of trailing words is the set-bit count of the mask, and the words target base + b for each set bit b, in ascending order.
- R5: Imm (0x4) gives out_imm = bits 15:0. Restart (0x5) and restart_w (0xD) give out_addr = in_word shifted left by 4. Setstrmid (0x7) gives out_offset = bits 21:0. Setappid (0x8) gives out_imm = bits 7:0. No words trail any of these.
- R6: Gather (0x6) gives out_offset = bits 27:16, out_insert = bit 15, out_type = bit 14 and out_count = bits 13:0, and one address word trails it. Gather_w (0xC) gives out_count = bits 13:0, and two address words trail it. An address word has out_is_data = 1, out_is_addr = 1, out_addr = the word and out_offset = 0.
- R7: Setpyld (0x9) gives out_imm = bits 15:0 and stores that value as the payload length. Incr_w (0xA) and nonincr_w (0xB) give out_offset = bits 21:0, and as many data words trail them as the stored length. They follow the incr and nonincr offset rules.
- R8: While the payload length is invalid, incr_w and nonincr_w raise out_bad_payload and take no trailing words. When the length is zero they take no trailing words and do not raise the flag.
- R9: Extend (0xE) gives out_sub = bits 27:24 and out_imm = bits 7:0. Sub-opcode 0 means acquire and 1 means release. Any other sub-opcode raises out_ext_unknown. No words trail an extend.
- R10: out_valid equals in_valid and in_ready equals out_ready. State moves on only when in_valid and out_ready are both high. A stalled word keeps its record and is decoded exactly once.
- R11: A synchronous reset makes the next accepted word a command and returns the payload length to invalid. After reset, out_valid is 0 while in_valid is 0.
- R12: A data word shows out_is_data = 1 and carries the opcode of the command it belongs to. Its class, mask, count, imm, insert, type, sub, flag and out_trail outputs are 0. A command word shows out_is_data = 0, and out_trail gives how many words follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Parser can take the word |
| in_word | input | 32 | Command or data word |
| out_valid | output | 1 | Record valid |
| out_ready | input | 1 | Consumer takes the record |
| out_opcode | output | 4 | Opcode of the word or of the command it belongs to |
| out_is_data | output | 1 | Word trails a command |
| out_is_addr | output | 1 | Trailing word is a gather address |
| out_offset | output | 22 | Command offset field, or the target offset of a data word |
| out_class | output | 10 | Class field of setclass |
| out_mask | output | 16 | Mask field |
| out_count | output | 16 | Count field |
| out_imm | output | 16 | Immediate, payload, id or index field |
| out_addr | output | 32 | Restart target or gather address word |
| out_insert | output | 1 | Gather insert flag |
| out_type | output | 1 | Gather type flag |
| out_sub | output | 4 | Extend sub-opcode |
| out_unknown | output | 1 | Opcode 0xF |
| out_ext_unknown | output | 1 | Extend with a sub-opcode other than 0 or 1 |
| out_bad_payload | output | 1 | Wide write issued while the payload length is invalid |
| out_trail | output | 16 | Number of words that follow this command |

## Verification
Each opcode is sent with its own field pattern, each followed by its trailing words. Setclass and mask use sparse masks with gaps, and a mask with only its lowest and highest bits set, so the ascending walk over set bits shows up against any other bit order. Incr and nonincr, and their wide forms, run over several words, so a stepping offset and a fixed offset lead to different results. Zero counts, a zero mask, a zero payload and an invalid payload, both after the first reset and after a reset in mid-stream, show whether the next word is treated as a command. Stalls placed on data words and on command words show whether a word is lost or counted twice.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;
  localparam int WORD_W  = 32;
  localparam int OFF_W   = 22;
  localparam int SOFF_W  = 12;
  localparam int CNT_W   = 16;
  localparam int CLS_W   = 10;
  localparam int SUB_W   = 4;
  localparam int IDX_W   = $clog2(CNT_W);
  localparam int PYLD_W  = CNT_W + 1;

  typedef enum logic [3:0] {
    OP_SETCL   = 4'h0, OP_INCR    = 4'h1, OP_NONINCR = 4'h2, OP_MASK   = 4'h3,
    OP_IMM     = 4'h4, OP_RESTART = 4'h5, OP_GATHER  = 4'h6, OP_STRMID = 4'h7,
    OP_APPID   = 4'h8, OP_PYLD    = 4'h9, OP_INCR_W  = 4'hA, OP_NINCR_W = 4'hB,
    OP_GATH_W  = 4'hC, OP_RSTRT_W = 4'hD, OP_EXTEND  = 4'hE, OP_BAD    = 4'hF
  } op_e;

  typedef enum logic [1:0] {DM_FIXED, DM_STEP, DM_SPARSE, DM_ADDR} dmode_e;

  typedef struct packed {
    op_e                opcode;
    logic [CLS_W-1:0]   cls;
    logic [CNT_W-1:0]   mask;
    logic [CNT_W-1:0]   count;
    logic [CNT_W-1:0]   imm;
    logic [OFF_W-1:0]   offset;
    logic [WORD_W-1:0]  addr;
    logic               ins;
    logic               typ;
    logic [SUB_W-1:0]   sub;
    logic               unknown;
    logic               ext_unknown;
    logic               needs_pyld;
    logic               pyld_wr;
    logic [CNT_W-1:0]   trail;
    dmode_e             mode;
  } cmd_rec_t;

  function automatic logic [CNT_W-1:0] ones_in(input logic [CNT_W-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < CNT_W; i++) n = n + CNT_W'(v[i]);
    return n;
  endfunction

  function automatic logic [IDX_W-1:0] low_idx(input logic [CNT_W-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = CNT_W - 1; i >= 0; i--) if (v[i]) r = IDX_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/cmdp_decode.sv
module cmdp_decode
  import cmdp_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output cmd_rec_t          rec
);
  logic [OFF_W-1:0] short_off;
  logic [OFF_W-1:0] wide_off;
  assign short_off = OFF_W'(word[27:16]);
  assign wide_off  = word[OFF_W-1:0];

  always_comb begin
    rec        = '0;
    rec.opcode = op_e'(word[31:28]);
    rec.mode   = DM_FIXED;
    case (rec.opcode)
      OP_SETCL: begin
        rec.cls    = word[15:6];
        rec.offset = short_off;
        rec.mask   = CNT_W'(word[5:0]);
        rec.trail  = ones_in(CNT_W'(word[5:0]));
        rec.mode   = DM_SPARSE;
      end
      OP_INCR, OP_NONINCR: begin
        rec.offset = short_off;
        rec.count  = word[15:0];
        rec.trail  = word[15:0];
        rec.mode   = (rec.opcode == OP_INCR) ? DM_STEP : DM_FIXED;
      end
      OP_MASK: begin
        rec.offset = short_off;
        rec.mask   = word[15:0];
        rec.trail  = ones_in(word[15:0]);
        rec.mode   = DM_SPARSE;
      end
      OP_IMM: begin
        rec.offset = short_off;
        rec.imm    = word[15:0];
      end
      OP_RESTART, OP_RSTRT_W: rec.addr = {word[27:0], 4'b0000};
      OP_GATHER: begin
        rec.offset = short_off;
        rec.ins    = word[15];
        rec.typ    = word[14];
        rec.count  = CNT_W'(word[13:0]);
        rec.trail  = CNT_W'(1);
        rec.mode   = DM_ADDR;
      end
      OP_STRMID: rec.offset = wide_off;
      OP_APPID:  rec.imm    = CNT_W'(word[7:0]);
      OP_PYLD: begin
        rec.imm     = word[15:0];
        rec.pyld_wr = 1'b1;
      end
      OP_INCR_W, OP_NINCR_W: begin
        rec.offset     = wide_off;
        rec.needs_pyld = 1'b1;
        rec.mode       = (rec.opcode == OP_INCR_W) ? DM_STEP : DM_FIXED;
      end
      OP_GATH_W: begin
        rec.count = CNT_W'(word[13:0]);
        rec.trail = CNT_W'(2);
        rec.mode  = DM_ADDR;
      end
      OP_EXTEND: begin
        rec.sub         = word[27:24];
        rec.imm         = CNT_W'(word[7:0]);
        rec.ext_unknown = (word[27:24] > 4'd1);
      end
      default: rec.unknown = 1'b1;
    endcase
  end
endmodule

// File: rtl/cmdp_track.sv
module cmdp_track
  import cmdp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [CNT_W-1:0]  start_trail,
  input  dmode_e            start_mode,
  input  logic [OFF_W-1:0]  start_off,
  input  logic [CNT_W-1:0]  start_mask,
  input  op_e               start_op,
  input  logic              pyld_wr,
  input  logic [CNT_W-1:0]  pyld_data,
  output logic              in_cmd,
  output logic [CNT_W-1:0]  remain_q,
  output dmode_e            mode_q,
  output logic [OFF_W-1:0]  off_q,
  output logic [CNT_W-1:0]  mask_q,
  output op_e               op_q,
  output logic [PYLD_W-1:0] pyld_q
);
  assign in_cmd = (remain_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
      mode_q   <= DM_FIXED;
      off_q    <= '0;
      mask_q   <= '0;
      op_q     <= OP_SETCL;
      pyld_q   <= '1;
    end else if (fire) begin
      if (in_cmd) begin
        remain_q <= start_trail;
        mode_q   <= start_mode;
        off_q    <= start_off;
        mask_q   <= start_mask;
        op_q     <= start_op;
        if (pyld_wr) pyld_q <= {1'b0, pyld_data};
      end else begin
        remain_q <= remain_q - CNT_W'(1);
        if (mode_q == DM_STEP)   off_q  <= off_q + OFF_W'(1);
        if (mode_q == DM_SPARSE) mask_q <= mask_q & (mask_q - CNT_W'(1));
      end
    end
  end
endmodule

// File: rtl/cmd_stream_parser.sv
module cmd_stream_parser
  import cmdp_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [WORD_W-1:0]  in_word,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [3:0]         out_opcode,
  output logic               out_is_data,
  output logic               out_is_addr,
  output logic [OFF_W-1:0]   out_offset,
  output logic [CLS_W-1:0]   out_class,
  output logic [CNT_W-1:0]   out_mask,
  output logic [CNT_W-1:0]   out_count,
  output logic [CNT_W-1:0]   out_imm,
  output logic [WORD_W-1:0]  out_addr,
  output logic               out_insert,
  output logic               out_type,
  output logic [SUB_W-1:0]   out_sub,
  output logic               out_unknown,
  output logic               out_ext_unknown,
  output logic               out_bad_payload,
  output logic [CNT_W-1:0]   out_trail
);
  cmd_rec_t          rec;
  logic              fire, cmd_fire, data_fire, in_cmd, pyld_inv;
  logic [CNT_W-1:0]  remain_q, mask_q, eff_trail;
  logic [OFF_W-1:0]  off_q;
  logic [PYLD_W-1:0] pyld_q;
  dmode_e            mode_q;
  op_e               op_q;

  assign out_valid = in_valid;
  assign in_ready  = out_ready;
  assign fire      = in_valid & out_ready;
  assign cmd_fire  = fire & in_cmd;
  assign data_fire = fire & ~in_cmd;
  assign pyld_inv  = &pyld_q;
  assign eff_trail = rec.needs_pyld ? (pyld_inv ? '0 : pyld_q[CNT_W-1:0]) : rec.trail;

  cmdp_decode u_dec (.word(in_word), .rec(rec));

  cmdp_track u_trk (
    .clk(clk), .rst(rst), .fire(fire),
    .start_trail(eff_trail), .start_mode(rec.mode), .start_off(rec.offset),
    .start_mask(rec.mask), .start_op(rec.opcode),
    .pyld_wr(rec.pyld_wr), .pyld_data(rec.imm),
    .in_cmd(in_cmd), .remain_q(remain_q), .mode_q(mode_q), .off_q(off_q),
    .mask_q(mask_q), .op_q(op_q), .pyld_q(pyld_q)
  );

  always_comb begin
    out_opcode      = rec.opcode;
    out_is_data     = 1'b0;
    out_is_addr     = 1'b0;
    out_offset      = rec.offset;
    out_class       = rec.cls;
    out_mask        = rec.mask;
    out_count       = rec.count;
    out_imm         = rec.imm;
    out_addr        = rec.addr;
    out_insert      = rec.ins;
    out_type        = rec.typ;
    out_sub         = rec.sub;
    out_unknown     = rec.unknown;
    out_ext_unknown = rec.ext_unknown;
    out_bad_payload = rec.needs_pyld & pyld_inv;
    out_trail       = eff_trail;
    if (!in_cmd) begin
      out_opcode      = op_q;
      out_is_data     = 1'b1;
      out_is_addr     = (mode_q == DM_ADDR);
      out_class       = '0;
      out_mask        = '0;
      out_count       = '0;
      out_imm         = '0;
      out_insert      = 1'b0;
      out_type        = 1'b0;
      out_sub         = '0;
      out_unknown     = 1'b0;
      out_ext_unknown = 1'b0;
      out_bad_payload = 1'b0;
      out_trail       = '0;
      out_addr        = (mode_q == DM_ADDR) ? in_word : '0;
      case (mode_q)
        DM_SPARSE: out_offset = off_q + OFF_W'(low_idx(mask_q));
        DM_ADDR:   out_offset = '0;
        default:   out_offset = off_q;
      endcase
    end
  end
endmodule

// File: rtl/cmdp_checker.sv
module cmdp_checker
  import cmdp_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             out_ready,
  input logic             out_valid,
  input logic             out_is_data,
  input logic             out_is_addr,
  input logic             out_unknown,
  input logic             out_bad_payload,
  input logic [CNT_W-1:0] out_trail,
  input logic             cmd_fire,
  input logic             data_fire,
  input logic [CNT_W-1:0] remain_q
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R11: the cycle after a reset the counter is empty
  always @(posedge clk) begin
    if (rst_q === 1'b1) begin
      assert_reset_clear_R11: assert (remain_q == '0);
    end
  end

  assert_load_trail_R3: assert property (@(posedge clk) disable iff (rst)
    cmd_fire |=> remain_q == $past(out_trail));

  assert_data_step_R10: assert property (@(posedge clk) disable iff (rst)
    data_fire |=> remain_q == $past(remain_q) - CNT_W'(1));

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !out_ready) |=> $stable(remain_q));

  assert_unknown_none_R1: assert property (@(posedge clk) disable iff (rst)
    (cmd_fire && out_unknown) |-> out_trail == '0);

  assert_bad_none_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_bad_payload) |-> (out_trail == '0 && !out_is_data));

  assert_addr_is_data_R6: assert property (@(posedge clk) disable iff (rst)
    out_is_addr |-> out_is_data);
endmodule

bind cmd_stream_parser cmdp_checker u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_ready(out_ready),
  .out_valid(out_valid), .out_is_data(out_is_data), .out_is_addr(out_is_addr),
  .out_unknown(out_unknown), .out_bad_payload(out_bad_payload),
  .out_trail(out_trail), .cmd_fire(cmd_fire), .data_fire(data_fire),
  .remain_q(remain_q)
);

// File: tb/cmd_stream_parser_tb.sv
module cmd_stream_parser_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic [31:0] in_word = '0;
  logic in_ready, out_valid, out_is_data, out_is_addr, out_insert, out_type;
  logic out_unknown, out_ext_unknown, out_bad_payload;
  logic [3:0]  out_opcode, out_sub;
  logic [21:0] out_offset;
  logic [9:0]  out_class;
  logic [15:0] out_mask, out_count, out_imm, out_trail;
  logic [31:0] out_addr;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  cmd_stream_parser u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_opcode(out_opcode),
    .out_is_data(out_is_data), .out_is_addr(out_is_addr), .out_offset(out_offset),
    .out_class(out_class), .out_mask(out_mask), .out_count(out_count), .out_imm(out_imm),
    .out_addr(out_addr), .out_insert(out_insert), .out_type(out_type), .out_sub(out_sub),
    .out_unknown(out_unknown), .out_ext_unknown(out_ext_unknown),
    .out_bad_payload(out_bad_payload), .out_trail(out_trail)
  );

  // behavioural reference state
  int m_rem = 0;
  int m_pyld = -1;
  int m_op = 0;
  bit m_addr = 0;
  int m_offq[$];

  function automatic int bits_set(input logic [15:0] v);
    int n = 0;
    for (int i = 0; i < 16; i++) if (v[i]) n++;
    return n;
  endfunction

  task automatic bdecode(input logic [31:0] w, output logic [142:0] v, output int trail,
                         output int kind, output int base, output logic [15:0] msk);
    int op, cls, cnt, imm, sub, unk, extu, bad, ins, typ;
    logic [31:0] adr;
    op = int'(w[31:28]);
    cls = 0; cnt = 0; imm = 0; sub = 0; unk = 0; extu = 0; bad = 0; ins = 0; typ = 0;
    adr = '0; trail = 0; kind = 0; base = 0; msk = '0;
    case (op)
      0: begin cls = int'(w[15:6]); base = int'(w[27:16]); msk = {10'b0, w[5:0]};
               trail = bits_set(msk); kind = 3; end
      1, 2: begin base = int'(w[27:16]); cnt = int'(w[15:0]); trail = cnt;
                  kind = (op == 1) ? 1 : 2; end
      3: begin base = int'(w[27:16]); msk = w[15:0]; trail = bits_set(msk); kind = 3; end
      4: begin base = int'(w[27:16]); imm = int'(w[15:0]); end
      5, 13: adr = w << 4;
      6: begin base = int'(w[27:16]); ins = int'(w[15]); typ = int'(w[14]);
               cnt = int'(w[13:0]); trail = 1; kind = 4; end
      7: base = int'(w[21:0]);
      8: imm = int'(w[7:0]);
      9: imm = int'(w[15:0]);
      10, 11: begin base = int'(w[21:0]); kind = (op == 10) ? 1 : 2;
                    if (m_pyld < 0) bad = 1; else trail = m_pyld; end
      12: begin cnt = int'(w[13:0]); trail = 2; kind = 4; end
      14: begin sub = int'(w[27:24]); imm = int'(w[7:0]); extu = (sub > 1) ? 1 : 0; end
      default: unk = 1;
    endcase
    v = {4'(op), 1'b0, 1'b0, 22'(base), 10'(cls), msk, 16'(cnt), 16'(imm), adr,
         1'(ins), 1'(typ), 4'(sub), 1'(unk), 1'(extu), 1'(bad), 16'(trail)};
  endtask

  task automatic expect_vec(input logic [31:0] w, output logic [142:0] v);
    int t, k, b;
    logic [15:0] mk;
    if (m_rem == 0) begin
      bdecode(w, v, t, k, b, mk);
    end else begin
      v = {4'(m_op), 1'b1, m_addr, (m_addr ? 22'd0 : 22'(m_offq[0])), 10'd0, 16'd0,
           16'd0, 16'd0, (m_addr ? w : 32'd0), 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 16'd0};
    end
  endtask

  task automatic model_advance(input logic [31:0] w);
    logic [142:0] v;
    int t, k, b;
    logic [15:0] mk;
    if (m_rem == 0) begin
      bdecode(w, v, t, k, b, mk);
      if (w[31:28] == 4'h9) m_pyld = int'(w[15:0]);
      m_offq.delete();
      if (k == 3) begin
        for (int i = 0; i < 16; i++) if (mk[i]) m_offq.push_back((b + i) & 32'h3FFFFF);
      end else begin
        for (int i = 0; i < t; i++) begin
          if (k == 1) m_offq.push_back((b + i) & 32'h3FFFFF);
          else if (k == 2) m_offq.push_back(b);
          else m_offq.push_back(0);
        end
      end
      m_rem = t;
      m_op = int'(w[31:28]);
      m_addr = (k == 4);
    end else begin
      void'(m_offq.pop_front());
      m_rem--;
    end
  endtask

  function automatic logic [142:0] actual_vec();
    return {out_opcode, out_is_data, out_is_addr, out_offset, out_class, out_mask,
            out_count, out_imm, out_addr, out_insert, out_type, out_sub, out_unknown,
            out_ext_unknown, out_bad_payload, out_trail};
  endfunction

  task automatic step(input logic [31:0] w, input int stall, input string tag);
    logic [142:0] ev;
    for (int s = 0; s <= stall; s++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_word = w;
      out_ready = (s == stall);
      #1;
      expect_vec(w, ev);
      checks++;
      if (actual_vec() !== ev) begin
        failures++;
        $display("FAIL %s word=%08h record actual=%036h expected=%036h", tag, w, actual_vec(), ev);
      end
      checks++;
      if (in_ready !== out_ready || out_valid !== 1'b1) begin
        failures++;
        $display("FAIL R10 handshake actual ready=%b valid=%b expected ready=%b valid=1",
                 in_ready, out_valid, out_ready);
      end
    end
    @(posedge clk);
    model_advance(w);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_rem = 0; m_pyld = -1; m_offq.delete(); m_addr = 0; m_op = 0;
    #1;
    checks++;
    if (out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R11 idle out_valid actual=%b expected=0", out_valid);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    // R8 / R11: payload invalid after reset
    step(32'hA0000123, 0, "R8");
    step(32'h90000000, 0, "R7");
    step(32'hB0000040, 0, "R8");
    // R2 setclass, sparse 6-bit mask 101001
    step(32'h003004A9, 0, "R2");
    step(32'h11111111, 0, "R2");
    step(32'h22222222, 1, "R2");
    step(32'h33333333, 0, "R2");
    // R3 incr with stalls, nonincr
    step(32'h11000003, 2, "R3");
    step(32'hAAAA0001, 0, "R3");
    step(32'hAAAA0002, 3, "R10");
    step(32'hAAAA0003, 0, "R3");
    step(32'h22000002, 0, "R3");
    step(32'hBBBB0001, 0, "R3");
    step(32'hBBBB0002, 0, "R3");
    step(32'h10050000, 0, "R3");
    // R4 mask lowest and highest bits, then zero mask
    step(32'h30408001, 0, "R4");
    step(32'hCCCC0001, 0, "R4");
    step(32'hCCCC0002, 1, "R4");
    step(32'h30400000, 0, "R4");
    // R5 no-trail commands
    step(32'h4123ABCD, 0, "R5");
    step(32'h5ABCDEF1, 0, "R5");
    step(32'hD0000010, 0, "R5");
    step(32'h70123456, 0, "R5");
    step(32'h800000AB, 0, "R5");
    // R6 gathers
    step(32'h6010C005, 0, "R6");
    step(32'h80001000, 1, "R6");
    step(32'hC0000007, 0, "R6");
    step(32'h12345678, 0, "R6");
    step(32'h9ABCDEF0, 0, "R6");
    // R7 wide writes with a payload of 3
    step(32'h90000003, 0, "R7");
    step(32'hA0001000, 0, "R7");
    step(32'hD0D00001, 0, "R12");
    step(32'hD0D00002, 2, "R7");
    step(32'hD0D00003, 0, "R7");
    step(32'hB0000777, 0, "R7");
    step(32'hE0E00001, 0, "R7");
    step(32'hE0E00002, 0, "R12");
    step(32'hE0E00003, 0, "R7");
    // R9 extend
    step(32'hE0000005, 0, "R9");
    step(32'hE1000006, 1, "R9");
    step(32'hE5000007, 0, "R9");
    // R1 unknown
    step(32'hF1234567, 0, "R1");
    step(32'h4000FFFF, 0, "R1");
    // R11 reset in the middle of a data run
    step(32'h11000004, 0, "R11");
    step(32'h55550001, 0, "R11");
    do_reset();
    step(32'h4001BEEF, 0, "R11");
    step(32'hA0000010, 0, "R11");
    step(32'h4002CAFE, 0, "R11");
    @(negedge clk);
    in_valid = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule